// File: doc/BRIEF.md
# Output Voltage Setpoint Sequencer

This block turns a three-bit level selection and an on/off request into a digital code for the output DAC of a dish-feed supply. The code moves toward its destination by a bounded amount on each ramp tick, so both start-up and level changes are slew-limited. The tick comes from a divider outside the block and so sets the slew rate. The block also drives the output-on signal to the regulator. A fault input removes that signal in the same cycle.

A digitised measurement of the output is compared against the selected level to produce a power-not-good flag. Separate under- and over-voltage windows are expressed as percentages of the target, and each has its own hysteresis. The flag reads 1 whenever the output is off. The voltage code counts in thirds of a volt, so every level is an integer code. The measurement counts in finer units, `MEAS_SCALE` per code step.

Top module: `lnb_setpoint_seq`

## Requirements
- R1: While reset is asserted and just after it is released, `dac_o` is 0, `out_en_o` is 0 and `png_o` is 1.
- R2: The level selected by `sel_i` is, in code units: 0→40, 1→41, 2→42, 3→43 (low band, `sel_i[2]`=0) and 4→56, 5→57, 6→59, 7→60 (high band, `sel_i[2]`=1).
- R3: `dac_o` changes only in the cycle after a cycle with `tick_i`=1. It then moves by one code toward its destination and stops when it equals it.
- R4: While the output is requested on (`en_i`=1, `fault_i`=0), the destination is the selected level. Start-up from 0 and every level change therefore ramp and never overshoot.
- R5: While `en_i`=0 or `fault_i`=1, the destination is 0 and `dac_o` ramps down on ticks.
- R6: `out_en_o` equals the value of `en_i & ~fault_i` registered at the previous clock edge, masked at once by the current `fault_i`. A fault removes the output in the same cycle.
- R7: `png_o` is 1 whenever `out_en_o` is 0.
- R8: Under-voltage: with T = level×`MEAS_SCALE` (default 4), the under flag sets when 100×`meas_i` < 91×T and clears when 100×`meas_i` ≥ 95×T. It holds its value in between.
- R9: Over-voltage: the over flag sets when 100×`meas_i` > 109×T and clears when 100×`meas_i` ≤ 105×T. It holds its value in between. The under and over flags are never both set.
- R10: While the output is off, the under flag is held set and the over flag is held clear. After enabling, `png_o` therefore stays 1 until the measurement first reaches 95% of T.
- R11: With the output on, `png_o` equals the OR of the under and over flags, which update one clock after `meas_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 3 | Level selection; bit 2 picks the band |
| en_i | input | 1 | Output-on request |
| fault_i | input | 1 | Forces the output off immediately |
| tick_i | input | 1 | Ramp tick, one code step per tick |
| meas_i | input | MEAS_W (10) | Measured output, `MEAS_SCALE` units per code step |
| dac_o | output | CODE_W (8) | Ramped DAC code |
| out_en_o | output | 1 | Output on |
| png_o | output | 1 | Power not good |

## Verification
Assertions check the cycle-level rules on every cycle. The DAC code holds when there is no tick and moves toward its destination without passing it. A fault removes the output in the same cycle. The flag reads not-good whenever the output is off, the two window flags never coexist, and the band bit picks the level range. The exact level values, the threshold boundaries on both sides of each hysteresis band, and the preset-under behaviour after enabling can only be shown by the bench's directed scenarios. The random phase mixes level changes, faults and irregular ticks against a cycle model.

// File: rtl/lnb_seq_pkg.sv
package lnb_seq_pkg;

   typedef enum logic {
      BAND_LOW  = 1'b0,
      BAND_HIGH = 1'b1
   } band_e;

   // Level code for one selection; the high band skips one code between
   // its second and third entries.
   function automatic int level_of(input logic [2:0] sel, input int lo_base, input int hi_base);
      int off;
      off = int'(sel[1:0]);
      if (sel[2]) begin
         return hi_base + off + int'(sel[1]);
      end
      return lo_base + off;
   endfunction

endpackage

// File: rtl/lnb_level_map.sv
module lnb_level_map #(
   parameter int CODE_W    = 8,
   parameter int LOW_BASE  = 40,
   parameter int HIGH_BASE = 56,
   parameter bit USE_TABLE = 1'b1
) (
   input  logic [2:0]        sel_i,
   output logic [CODE_W-1:0] code_o
);
   import lnb_seq_pkg::*;

   localparam int NUM_LEVELS = 8;

   if (USE_TABLE) begin : g_table
      logic [CODE_W-1:0] lut [NUM_LEVELS];
      for (genvar k = 0; k < NUM_LEVELS; k++) begin : g_ent
         assign lut[k] = CODE_W'(level_of(3'(k), LOW_BASE, HIGH_BASE));
      end
      assign code_o = lut[sel_i];
   end else begin : g_arith
      band_e             band;
      logic [CODE_W-1:0] base;
      logic [2:0]        off;
      always_comb begin
         band   = sel_i[2] ? BAND_HIGH : BAND_LOW;
         base   = (band == BAND_HIGH) ? CODE_W'(HIGH_BASE) : CODE_W'(LOW_BASE);
         off    = {1'b0, sel_i[1:0]} + {2'b00, (band == BAND_HIGH) & sel_i[1]};
         code_o = base + CODE_W'(off);
      end
   end

endmodule

// File: rtl/lnb_slew_ramp.sv
module lnb_slew_ramp #(
   parameter int CODE_W    = 8,
   parameter int RAMP_STEP = 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic [CODE_W-1:0] tgt_i,
   output logic [CODE_W-1:0] dac_o
);
   localparam logic [CODE_W-1:0] STEP = CODE_W'(RAMP_STEP);

   logic [CODE_W-1:0] dac_q, dac_d;

   if (RAMP_STEP == 1) begin : g_unit
      always_comb begin
         dac_d = dac_q;
         if (dac_q < tgt_i)      dac_d = dac_q + 1'b1;
         else if (dac_q > tgt_i) dac_d = dac_q - 1'b1;
      end
   end else begin : g_multi
      logic [CODE_W-1:0] gap;
      always_comb begin
         dac_d = dac_q;
         gap   = '0;
         if (dac_q < tgt_i) begin
            gap   = tgt_i - dac_q;
            dac_d = (gap > STEP) ? dac_q + STEP : tgt_i;
         end else if (dac_q > tgt_i) begin
            gap   = dac_q - tgt_i;
            dac_d = (gap > STEP) ? dac_q - STEP : tgt_i;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     dac_q <= '0;
      else if (tick_i) dac_q <= dac_d;
   end

   assign dac_o = dac_q;

   // R3: no tick, no movement
   p_hold_no_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(dac_o));
   // R3: a tick below the destination raises the code
   p_move_up_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && dac_o < tgt_i) |=> dac_o > $past(dac_o));
   // R4: rising never passes the destination
   p_no_overshoot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && dac_o <= tgt_i) |=> dac_o <= $past(tgt_i));
   // R5: falling never passes the destination
   p_no_undershoot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && dac_o >= tgt_i) |=> dac_o >= $past(tgt_i));

endmodule

// File: rtl/lnb_pwr_window.sv
module lnb_pwr_window #(
   parameter int CODE_W     = 8,
   parameter int MEAS_W     = 10,
   parameter int MEAS_SCALE = 4,
   parameter int LO_PCT     = 91,
   parameter int HI_PCT     = 109,
   parameter int HYST_PCT   = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              live_i,
   input  logic [CODE_W-1:0] tgt_i,
   input  logic [MEAS_W-1:0] meas_i,
   output logic              under_o,
   output logic              over_o
);
   localparam int PW = 32;

   logic [PW-1:0] meas_x100, tgt_m;
   logic [PW-1:0] lo_trip, lo_free, hi_trip, hi_free;
   logic          lo_set, lo_clr, hi_set, hi_clr;
   logic          under_q, over_q, under_d, over_d;

   always_comb begin
      meas_x100 = PW'(meas_i) * PW'(100);
      tgt_m     = PW'(tgt_i) * PW'(MEAS_SCALE);
      lo_trip   = tgt_m * PW'(LO_PCT);
      lo_free   = tgt_m * PW'(LO_PCT + HYST_PCT);
      hi_trip   = tgt_m * PW'(HI_PCT);
      hi_free   = tgt_m * PW'(HI_PCT - HYST_PCT);
      lo_set    = meas_x100 <  lo_trip;
      lo_clr    = meas_x100 >= lo_free;
      hi_set    = meas_x100 >  hi_trip;
      hi_clr    = meas_x100 <= hi_free;
   end

   if (HYST_PCT == 0) begin : g_plain
      always_comb begin
         under_d = lo_set;
         over_d  = hi_set;
      end
   end else begin : g_hyst
      always_comb begin
         under_d = lo_set | (under_q & ~lo_clr);
         over_d  = hi_set | (over_q  & ~hi_clr);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         under_q <= 1'b1;
         over_q  <= 1'b0;
      end else if (!live_i) begin
         under_q <= 1'b1;
         over_q  <= 1'b0;
      end else begin
         under_q <= under_d;
         over_q  <= over_d;
      end
   end

   assign under_o = under_q;
   assign over_o  = over_q;

   // R9: the two window flags are mutually exclusive
   p_flags_exclusive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({under_q, over_q}));
   // R10: an off cycle leaves the under flag set for the next cycle
   p_off_preset_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !live_i |=> (under_o && !over_o));

endmodule

// File: rtl/lnb_setpoint_seq.sv
module lnb_setpoint_seq #(
   parameter int CODE_W     = 8,
   parameter int MEAS_W     = 10,
   parameter int MEAS_SCALE = 4,
   parameter int LOW_BASE   = 40,
   parameter int HIGH_BASE  = 56,
   parameter int RAMP_STEP  = 1,
   parameter int LO_PCT     = 91,
   parameter int HI_PCT     = 109,
   parameter int HYST_PCT   = 4,
   parameter bit USE_TABLE  = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [2:0]        sel_i,
   input  logic              en_i,
   input  logic              fault_i,
   input  logic              tick_i,
   input  logic [MEAS_W-1:0] meas_i,
   output logic [CODE_W-1:0] dac_o,
   output logic              out_en_o,
   output logic              png_o
);
   localparam int TOP_LEVEL = HIGH_BASE + 4;

   if (TOP_LEVEL >= (1 << CODE_W)) begin : g_bad_code_w
      $error("CODE_W too narrow for the highest level");
   end
   if (LOW_BASE + 3 >= HIGH_BASE) begin : g_bad_bands
      $error("low band overlaps high band");
   end
   if (RAMP_STEP < 1) begin : g_bad_step
      $error("RAMP_STEP must be at least 1");
   end
   if (LO_PCT + HYST_PCT > 100 || HI_PCT - HYST_PCT < 100) begin : g_bad_window
      $error("hysteresis crosses the nominal level");
   end
   if (TOP_LEVEL * MEAS_SCALE * HI_PCT >= (1 << 30)) begin : g_bad_meas
      $error("window products overflow");
   end

   logic [CODE_W-1:0] level, dest;
   logic              live, on_q, under, over;

   lnb_level_map #(
      .CODE_W    (CODE_W),
      .LOW_BASE  (LOW_BASE),
      .HIGH_BASE (HIGH_BASE),
      .USE_TABLE (USE_TABLE)
   ) u_map (
      .sel_i  (sel_i),
      .code_o (level)
   );

   assign live = en_i & ~fault_i;
   assign dest = live ? level : '0;

   lnb_slew_ramp #(
      .CODE_W    (CODE_W),
      .RAMP_STEP (RAMP_STEP)
   ) u_ramp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .tgt_i  (dest),
      .dac_o  (dac_o)
   );

   lnb_pwr_window #(
      .CODE_W     (CODE_W),
      .MEAS_W     (MEAS_W),
      .MEAS_SCALE (MEAS_SCALE),
      .LO_PCT     (LO_PCT),
      .HI_PCT     (HI_PCT),
      .HYST_PCT   (HYST_PCT)
   ) u_win (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .live_i  (live),
      .tgt_i   (level),
      .meas_i  (meas_i),
      .under_o (under),
      .over_o  (over)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) on_q <= 1'b0;
      else         on_q <= live;
   end

   assign out_en_o = on_q & ~fault_i;
   assign png_o    = ~out_en_o | under | over;

   // R6: a fault removes the output in the same cycle
   p_fault_kills_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_i |-> !out_en_o);
   // R7: an off output always reads not good
   p_off_not_good_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !out_en_o |-> png_o);
   // R2: the band bit picks the level range
   p_band_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_i[2] |-> (level >= CODE_W'(HIGH_BASE)));
   p_band_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sel_i[2] |-> (level <= CODE_W'(LOW_BASE + 3)));

endmodule

// File: tb/test_lnb_setpoint_seq.sv
`timescale 1ns/1ps
module test_lnb_setpoint_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] sel = 3'd0;
   logic       en = 1'b0, fault = 1'b0, tick = 1'b0;
   logic [9:0] meas = '0;
   logic [7:0] dac;
   logic       out_en, png;

   int checks = 0, failures = 0, cycles = 0;
   bit done = 0, reported = 0, model_on = 0;

   // bench model state
   int  m_dac = 0;
   bit  m_on = 0, m_under = 1, m_over = 0;

   always #2.5 clk = ~clk;

   lnb_setpoint_seq i_lnb_setpoint_seq (
      .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .en_i(en), .fault_i(fault),
      .tick_i(tick), .meas_i(meas), .dac_o(dac), .out_en_o(out_en), .png_o(png)
   );

   function automatic int exp_level(input logic [2:0] s);
      case (s)
         3'd0: return 40;  3'd1: return 41;  3'd2: return 42;  3'd3: return 43;
         3'd4: return 56;  3'd5: return 57;  3'd6: return 59;  default: return 60;
      endcase
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      if (!reported) begin
         reported = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      end
      $finish;
   endtask

   // cycle model and per-cycle comparison, sampled 1 ns after the edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_dac = 0; m_on = 0; m_under = 1; m_over = 0;
      end else begin
         bit live;
         int tgt, t_m, m100;
         live = en && !fault;
         tgt  = live ? exp_level(sel) : 0;
         if (tick) begin
            if (m_dac < tgt) m_dac++;
            else if (m_dac > tgt) m_dac--;
         end
         m_on = live;
         if (!live) begin
            m_under = 1; m_over = 0;
         end else begin
            t_m  = exp_level(sel) * 4;
            m100 = int'(meas) * 100;
            if (m100 < t_m * 91) m_under = 1;
            else if (m100 >= t_m * 95) m_under = 0;
            if (m100 > t_m * 109) m_over = 1;
            else if (m100 <= t_m * 105) m_over = 0;
         end
      end
      #1;
      if (rst_n && model_on) begin
         bit e_en;
         e_en = m_on && !fault;
         chk("R3 R4 R5 dac", int'(dac), m_dac);
         chk("R6 out_en", int'(out_en), int'(e_en));
         chk("R7 R8 R9 R10 R11 png", int'(png), int'(!e_en || m_under || m_over));
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         failures++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'h5eed_0042));
      // R1: reset state
      cyc(3);
      chk("R1 dac in reset", int'(dac), 0);
      chk("R1 out_en in reset", int'(out_en), 0);
      chk("R1 png in reset", int'(png), 1);
      rst_n = 1'b1;
      cyc(2);
      chk("R1 dac after reset", int'(dac), 0);
      chk("R1 out_en after reset", int'(out_en), 0);
      model_on = 1;

      // R3: no tick, no ramp even when enabled
      en = 1'b1; sel = 3'd7;
      cyc(5);
      chk("R3 hold without tick", int'(dac), 0);
      chk("R6 out_en one cycle after request", int'(out_en), 1);
      // R4: one step per tick from 0
      tick = 1'b1; cyc(1); tick = 1'b0; cyc(2);
      chk("R3 single tick step", int'(dac), 1);

      // R2: every level, ramped with ticks every cycle
      tick = 1'b1;
      for (int s = 0; s < 8; s++) begin
         sel = 3'(s);
         cyc(80);
         chk("R2 level code", int'(dac), exp_level(3'(s)));
         meas = 10'(exp_level(3'(s)) * 4);
         cyc(2);
         chk("R11 png at nominal", int'(png), 0);
      end

      // R8 / R9 boundaries at level 40 (T = 160)
      sel = 3'd0; cyc(80);
      meas = 10'd160; cyc(2); chk("R8 nominal good", int'(png), 0);
      meas = 10'd146; cyc(2); chk("R8 just above 91%", int'(png), 0);
      meas = 10'd145; cyc(2); chk("R8 below 91% sets", int'(png), 1);
      meas = 10'd151; cyc(2); chk("R8 hysteresis holds", int'(png), 1);
      meas = 10'd152; cyc(2); chk("R8 95% clears", int'(png), 0);
      meas = 10'd174; cyc(2); chk("R9 just below 109%", int'(png), 0);
      meas = 10'd175; cyc(2); chk("R9 above 109% sets", int'(png), 1);
      meas = 10'd169; cyc(2); chk("R9 hysteresis holds", int'(png), 1);
      meas = 10'd168; cyc(2); chk("R9 105% clears", int'(png), 0);

      // R6 / R7: fault removes output in the same cycle
      @(negedge clk); fault = 1'b1; #1;
      chk("R6 fault immediate", int'(out_en), 0);
      chk("R7 png while faulted", int'(png), 1);
      cyc(3);
      // R5: ramps down toward 0 under fault
      chk("R5 ramping down", int'(dac), 37);
      fault = 1'b0; cyc(50);

      // R5: disable ramps to 0
      en = 1'b0; cyc(60);
      chk("R5 disabled reaches 0", int'(dac), 0);
      chk("R7 png while disabled", int'(png), 1);

      // R10: re-enable between 91% and 95% keeps png set
      meas = 10'd150; en = 1'b1; cyc(4);
      chk("R10 out_en on", int'(out_en), 1);
      chk("R10 preset under holds", int'(png), 1);
      meas = 10'd152; cyc(2);
      chk("R10 released at 95%", int'(png), 0);

      // random phase
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         tick = ($urandom_range(0, 2) != 0);
         if ($urandom_range(0, 40) == 0) sel = 3'($urandom_range(0, 7));
         if ($urandom_range(0, 60) == 0) en = ~en;
         fault = ($urandom_range(0, 50) == 0);
         meas = 10'(exp_level(sel) * 4 + int'($urandom_range(0, 48)) - 24);
      end
      cyc(2);
      done = 1;
      summary();
   end

endmodule